// File: doc/BRIEF.md
# Size-Selectable Double-Width Unsigned Divider

This block is a sequential unsigned divider. It divides a dividend that is twice the operand width by a divisor that is one operand width. It returns a quotient and a remainder, each one operand width, or it reports a divide error when the quotient cannot fit. A two-bit size input selects an operand width of 8, 16, 32 or 64 bits. A mode flag decides whether the 64-bit width is allowed at all.

A request is a single-cycle `start_i` pulse. The block captures every input on that cycle. It then runs one restoring shift-subtract step per clock, one step for each bit of the operand width. When it finishes, it pulses `done_o`. On the same cycle it writes the results into two output registers. The layout of the results depends on the size. Only the field that belongs to the selected width changes, and every other bit of the output registers keeps its value.

The block checks for a quotient that will not fit before it starts iterating. That check also catches a zero divisor. A request that faults, or that asks for a forbidden size, finishes on the cycle right after the start and does not touch the results.

Top module: `dwdiv_unit`

## Requirements
- R1: The size code on `size_i` selects the operand width W: 0 selects 8, 1 selects 16, 2 selects 32 and 3 selects 64. The dividend is `dividend_i[2W-1:0]`, and its high half is bits `[2W-1:W]`. The divisor is `divisor_i[W-1:0]`. Any input bits above these fields have no effect.
- R2: For an accepted request, the quotient is the dividend divided by the divisor, truncated toward zero. The remainder is the dividend minus the product of the quotient and the divisor, so it is always strictly smaller than the divisor.
- R3: For size code 0, the quotient goes to `res_lo_o[7:0]` and the remainder to `res_lo_o[15:8]`. All other bits of `res_lo_o`, and all of `res_hi_o`, keep their previous values.
- R4: For size codes 1, 2 and 3, the quotient goes to `res_lo_o[W-1:0]` and the remainder to `res_hi_o[W-1:0]`. Bits at W and above in both outputs keep their previous values.
- R5: When the high half of the dividend is greater than or equal to the divisor, the block raises `div_err_o` together with `done_o` in the cycle after the start cycle. Both result outputs stay unchanged, and `busy_o` never rises.
- R6: A divisor field of zero raises the same divide error, with the same timing as R5, and leaves the results unchanged.
- R7: Size code 3 with `wide_mode_i` low is rejected. The block raises `bad_size_o` with `done_o` in the cycle after the start cycle, with no divide error and no change to the results. Size code 3 with `wide_mode_i` high is accepted.
- R8: An accepted request holds `busy_o` high from the cycle after the start. `done_o` rises exactly W clock edges after the start edge and lasts one cycle. `busy_o` is low while `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. Input changes after the start cycle do not affect the running division.
- R10: After a synchronous active-low reset, `busy_o`, `done_o`, `div_err_o` and `bad_size_o` are low, and both result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse; sampled only while idle |
| size_i | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| wide_mode_i | input | 1 | High allows size code 3 |
| dividend_i | input | 128 | Double-width dividend; low 2W bits used |
| divisor_i | input | 64 | Divisor; low W bits used |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error (quotient overflow or zero divisor), valid with done |
| bad_size_o | output | 1 | Forbidden size rejected, valid with done |
| res_lo_o | output | 64 | Quotient field (and remainder byte for size code 0) |
| res_hi_o | output | 64 | Remainder field for size codes 1 to 3 |

## Verification
Two behaviours are the hardest to reach from the ports: a start pulse that arrives in the middle of an iteration, and inputs that change while a division is running. To exercise them, the stimulus changes every input on the cycle after the start. On some random runs it also fires a second start two cycles into the run, carrying a request that would otherwise be rejected at once. If that second start were taken, the done pulse would come early and carry the rejection flag.

The boundary of the overflow check is also rare under uniform random operands. Directed cases therefore place the dividend's high half exactly one below the divisor, and exactly equal to it, at every width.

// File: rtl/dwdiv_pkg.sv
// Package: shared types and helpers for the double-width divider.
// Assumes the widest operand is 64 bits, so four size codes cover 8 to 64.
package dwdiv_pkg;

    // Operand size code as seen on size_i
    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } opsize_e;

    // Number of selectable operand sizes
    localparam int unsigned LANES = 4;

    // Width in bits of the smallest operand size
    localparam int unsigned BASE_W = 8;

endpackage

// File: rtl/dwdiv_operand_prep.sv
// Module: dwdiv_operand_prep
// Slices the double-width dividend and the divisor for the selected size.
// It returns the high half, the low half left-aligned in an XLEN-bit word
// (so the iteration always shifts out of bit XLEN-1), the masked divisor,
// the operand width, the quotient-overflow condition and the size rejection.
// Assumes XLEN equals the widest lane, BASE_W << (LANES-1).
module dwdiv_operand_prep
    import dwdiv_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned CW  = $clog2(XLEN + 1)
) (
    input  logic [1:0]        size_i,
    input  logic              wide_mode_i,
    input  logic [2*XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0]   divisor_i,
    output logic [XLEN-1:0]   hi_o,
    output logic [XLEN-1:0]   lo_aligned_o,
    output logic [XLEN-1:0]   dsr_o,
    output logic [CW-1:0]     width_o,
    output logic              overflow_o,
    output logic              bad_size_o
);

    logic [XLEN-1:0] hi_l  [LANES];
    logic [XLEN-1:0] lo_l  [LANES];
    logic [XLEN-1:0] dsr_l [LANES];

    // One slicing lane per operand size
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned LW = BASE_W << g;
        if (LW >= XLEN) begin : g_full
            assign hi_l[g]  = dividend_i[2*XLEN-1:XLEN];
            assign lo_l[g]  = dividend_i[XLEN-1:0];
            assign dsr_l[g] = divisor_i;
        end else begin : g_part
            assign hi_l[g]  = {{(XLEN-LW){1'b0}}, dividend_i[2*LW-1:LW]};
            assign lo_l[g]  = {dividend_i[LW-1:0], {(XLEN-LW){1'b0}}};
            assign dsr_l[g] = {{(XLEN-LW){1'b0}}, divisor_i[LW-1:0]};
        end
    end

    // Select the lane for the requested size and derive the checks
    always_comb begin
        hi_o         = hi_l[size_i];
        lo_aligned_o = lo_l[size_i];
        dsr_o        = dsr_l[size_i];
        width_o      = CW'(BASE_W) << size_i;
        overflow_o   = (hi_o >= dsr_o);
        bad_size_o   = (size_i == SZ_B64) && !wide_mode_i;
    end

endmodule

// File: rtl/dwdiv_step.sv
// Module: dwdiv_step
// One restoring radix-2 division step. It shifts the next dividend bit
// (the MSB of quo_i) into the partial remainder, subtracts the divisor when
// the divisor fits, and shifts the resulting quotient bit into quo_i's LSB.
// Assumes rem_i < dsr_i, which keeps the shifted remainder within XLEN+1 bits.
module dwdiv_step #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] dsr_i,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] quo_o
);

    logic [XLEN:0] shifted;
    logic [XLEN:0] diff;
    logic          fits;

    // Trial subtraction and restore selection
    always_comb begin
        shifted = {rem_i, quo_i[XLEN-1]};
        diff    = shifted - {1'b0, dsr_i};
        fits    = (shifted >= {1'b0, dsr_i});
        rem_o   = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
        quo_o   = {quo_i[XLEN-2:0], fits};
    end

endmodule

// File: rtl/dwdiv_pack.sv
// Module: dwdiv_pack
// Merges a finished quotient and remainder into the current result words.
// The smallest size puts both values into the low 16 bits of the low word.
// Larger sizes write the quotient into the low word and the remainder into
// the high word. Bits outside the written field keep their value.
module dwdiv_pack
    import dwdiv_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned CW  = $clog2(XLEN + 1)
) (
    input  logic [1:0]      size_i,
    input  logic [XLEN-1:0] cur_lo_i,
    input  logic [XLEN-1:0] cur_hi_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    output logic [XLEN-1:0] nxt_lo_o,
    output logic [XLEN-1:0] nxt_hi_o
);

    logic [CW-1:0]   width;
    logic [XLEN-1:0] field;

    // Field mask for the operand width
    always_comb begin
        width = CW'(BASE_W) << size_i;
        field = {XLEN{1'b1}} >> (CW'(XLEN) - width);
    end

    // Size-dependent merge of the result fields
    always_comb begin
        nxt_lo_o = cur_lo_i;
        nxt_hi_o = cur_hi_i;
        if (size_i == SZ_B8) begin
            nxt_lo_o[2*BASE_W-1:0] = {rem_i[BASE_W-1:0], quo_i[BASE_W-1:0]};
        end else begin
            nxt_lo_o = (cur_lo_i & ~field) | (quo_i & field);
            nxt_hi_o = (cur_hi_i & ~field) | (rem_i & field);
        end
    end

endmodule

// File: rtl/dwdiv_unit.sv
// Module: dwdiv_unit (top)
// Sequential double-width unsigned divider with a start/busy/done handshake.
// A start while idle captures all inputs. Forbidden sizes and quotient
// overflow (including a zero divisor) finish on the next cycle with a flag.
// Other requests iterate W cycles, one restoring step per cycle, and then
// update the result words.
// Assumes start_i is only meaningful while busy_o is low.
module dwdiv_unit
    import dwdiv_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned CW  = $clog2(XLEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic              wide_mode_i,
    input  logic [2*XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0]   divisor_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              div_err_o,
    output logic              bad_size_o,
    output logic [XLEN-1:0]   res_lo_o,
    output logic [XLEN-1:0]   res_hi_o
);

    logic [XLEN-1:0] prep_hi, prep_lo, prep_dsr;
    logic [CW-1:0]   prep_width;
    logic            prep_ovf, prep_bad;

    logic            run_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN-1:0] rem_q, quo_q, dsr_q;
    logic [1:0]      size_q;
    logic            done_q, err_q, bsz_q;
    logic [XLEN-1:0] res_lo_q, res_hi_q;

    logic [XLEN-1:0] step_rem, step_quo;
    logic [XLEN-1:0] pack_lo, pack_hi;

    dwdiv_operand_prep #(.XLEN(XLEN)) u_prep (
        .size_i       (size_i),
        .wide_mode_i  (wide_mode_i),
        .dividend_i   (dividend_i),
        .divisor_i    (divisor_i),
        .hi_o         (prep_hi),
        .lo_aligned_o (prep_lo),
        .dsr_o        (prep_dsr),
        .width_o      (prep_width),
        .overflow_o   (prep_ovf),
        .bad_size_o   (prep_bad)
    );

    dwdiv_step #(.XLEN(XLEN)) u_step (
        .rem_i (rem_q),
        .quo_i (quo_q),
        .dsr_i (dsr_q),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    dwdiv_pack #(.XLEN(XLEN)) u_pack (
        .size_i   (size_q),
        .cur_lo_i (res_lo_q),
        .cur_hi_i (res_hi_q),
        .quo_i    (step_quo),
        .rem_i    (step_rem),
        .nxt_lo_o (pack_lo),
        .nxt_hi_o (pack_hi)
    );

    // Control, iteration state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            dsr_q    <= '0;
            size_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            bsz_q    <= 1'b0;
            res_lo_q <= '0;
            res_hi_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            bsz_q  <= 1'b0;
            if (!run_q) begin
                if (start_i) begin
                    if (prep_bad) begin
                        done_q <= 1'b1;
                        bsz_q  <= 1'b1;
                    end else if (prep_ovf) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        run_q  <= 1'b1;
                        cnt_q  <= prep_width;
                        rem_q  <= prep_hi;
                        quo_q  <= prep_lo;
                        dsr_q  <= prep_dsr;
                        size_q <= size_i;
                    end
                end
            end else begin
                rem_q <= step_rem;
                quo_q <= step_quo;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q    <= 1'b0;
                    done_q   <= 1'b1;
                    res_lo_q <= pack_lo;
                    res_hi_q <= pack_hi;
                end
            end
        end
    end

    // Output drive
    always_comb begin
        busy_o     = run_q;
        done_o     = done_q;
        div_err_o  = err_q;
        bad_size_o = bsz_q;
        res_lo_o   = res_lo_q;
        res_hi_o   = res_hi_q;
    end

    // R2: partial remainder stays below the divisor throughout the iteration
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < dsr_q));

    // R5: a divide error leaves both result words untouched
    a_r5_fault_keeps_results: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_err_o) |-> ($stable(res_lo_o) && $stable(res_hi_o)));

    // R7: a size rejection is a completion without a divide error and without writes
    a_r7_reject_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bad_size_o |-> (done_o && !div_err_o && $stable(res_lo_o) && $stable(res_hi_o)));

    // R8: completion never overlaps an active iteration
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: the step counter stays within the selected operand width
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> ((cnt_q != '0) && (cnt_q <= (CW'(BASE_W) << size_q))));

    // R8: a successful completion follows an iteration
    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_err_o && !bad_size_o) |-> $past(run_q));

    // R9: captured divisor and size do not move while iterating
    a_r9_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (!run_q || ($stable(dsr_q) && $stable(size_q))));

endmodule

// File: tb/test_dwdiv_unit.sv
// Self-checking bench for dwdiv_unit: seeded random and directed requests,
// compared against divide/modulus computed in bench functions.
module test_dwdiv_unit;

    localparam int unsigned XLEN       = 64;
    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        size_i = '0;
    logic              wide_mode_i = 1'b0;
    logic [2*XLEN-1:0] dividend_i = '0;
    logic [XLEN-1:0]   divisor_i = '0;
    logic              busy_o, done_o, div_err_o, bad_size_o;
    logic [XLEN-1:0]   res_lo_o, res_hi_o;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    bit          finished = 1'b0;
    logic [XLEN-1:0] exp_lo = '0;
    logic [XLEN-1:0] exp_hi = '0;

    dwdiv_unit #(.XLEN(XLEN)) i_dwdiv_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .size_i      (size_i),
        .wide_mode_i (wide_mode_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .div_err_o   (div_err_o),
        .bad_size_o  (bad_size_o),
        .res_lo_o    (res_lo_o),
        .res_hi_o    (res_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [63:0] mask1(int unsigned w);
        return {64{1'b1}} >> (64 - w);
    endfunction

    function automatic logic [127:0] mask2(int unsigned w);
        return {128{1'b1}} >> (128 - 2*w);
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one request and check timing, flags and result words
    task automatic run_op(int unsigned s, bit wide, logic [127:0] dvd, logic [63:0] dsr,
                          bit poke, string tag);
        int unsigned w;
        logic [127:0] n, q, r;
        logic [63:0]  d;
        int unsigned  kind;
        int unsigned  cycles;
        int unsigned  exp_cyc;
        logic         busy0;
        string        req;
        w = 8 << s;
        n = dvd & mask2(w);
        d = dsr & mask1(w);
        q = '0;
        r = '0;
        if (s == 3 && !wide) begin
            kind = 2; req = "R7";
        end else if (d == 0) begin
            kind = 1; req = "R6";
        end else if ((n >> w) >= {64'd0, d}) begin
            kind = 1; req = "R5";
        end else begin
            kind = 0;
            req  = (s == 0) ? "R3" : "R4";
            q = n / {64'd0, d};
            r = n % {64'd0, d};
            if (s == 0) begin
                exp_lo[15:0] = {r[7:0], q[7:0]};
            end else begin
                exp_lo = (exp_lo & ~mask1(w)) | (q[63:0] & mask1(w));
                exp_hi = (exp_hi & ~mask1(w)) | (r[63:0] & mask1(w));
            end
        end
        @(negedge clk);
        size_i = 2'(s); wide_mode_i = wide; dividend_i = dvd; divisor_i = dsr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R9: scramble inputs once the request has been captured
        dividend_i = {rnd64(), rnd64()}; divisor_i = rnd64();
        size_i = 2'($urandom()); wide_mode_i = 1'($urandom());
        busy0 = busy_o;
        cycles = 0;
        while (!done_o && cycles < 300) begin
            if (poke && cycles == 2) begin
                start_i = 1'b1; size_i = 2'd3; wide_mode_i = 1'b0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start_i = 1'b0;
        exp_cyc = (kind == 0) ? w : 0;
        check(done_o && cycles == exp_cyc, poke ? "R9/R8" : "R8", {tag, " done latency"},
              128'(cycles), 128'(exp_cyc));
        check(busy0 == (kind == 0), "R8", {tag, " busy after start"},
              128'(busy0), 128'(kind == 0));
        check({div_err_o, bad_size_o} == {kind == 1, kind == 2}, req, {tag, " flags"},
              128'({div_err_o, bad_size_o}), 128'({kind == 1, kind == 2}));
        check(res_lo_o == exp_lo, kind == 0 ? "R2" : req, {tag, " low result"}, 128'(res_lo_o), 128'(exp_lo));
        check(res_hi_o == exp_hi, kind == 0 ? "R2" : req, {tag, " high result"}, 128'(res_hi_o), 128'(exp_hi));
        @(negedge clk);
        check(!done_o, "R8", {tag, " done one cycle"}, 128'(done_o), 128'(0));
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0D17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, done_o, div_err_o, bad_size_o} == 4'b0 && res_lo_o == 0 && res_hi_o == 0,
              "R10", "reset state", {busy_o, done_o, div_err_o, bad_size_o, res_lo_o, res_hi_o}, 128'(0));

        // Directed corners for every size
        for (int s = 0; s < 4; s++) begin
            int unsigned w;
            logic [63:0] mx;
            w  = 8 << s;
            mx = mask1(w);
            run_op(s, 1, {64'd0, mx} << w | {64'd0, mx}, mx, 0, "R5 max dividend");
            run_op(s, 1, ({64'd0, mx - 1} << w) | {64'd0, mx}, mx, 0, "R2 largest fitting");
            run_op(s, 1, {64'd0, mx}, 64'd1, 0, "R2 divisor one");
            run_op(s, 1, ({64'd0, 64'd1} << w) | 128'd7, 64'd1, 0, "R5 divisor one overflow");
            run_op(s, 1, {64'd0, mx}, 64'd0, 0, "R6 zero divisor");
            run_op(s, 1, 128'd5, 64'd9, 0, "R2 small dividend");
            run_op(s, 1, ({64'd0, 64'd3} << w) | 128'd1, 64'd3, 0, "R5 high equals divisor");
            run_op(s, 1, ~mask2(w) | 128'd100, ~mx | 64'd7, 0, "R1 upper bits ignored");
        end
        run_op(3, 0, 128'd100, 64'd7, 0, "R7 forbidden size");
        run_op(3, 0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 64'd0, 0, "R7 forbidden size zero divisor");
        run_op(3, 1, 128'd100, 64'd7, 0, "R7 wide allowed");

        // Seeded random requests
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 30; i++) begin
                int unsigned w, cls;
                logic [63:0] d, hi, lo;
                logic [127:0] dvd;
                w   = 8 << s;
                cls = $urandom() % 8;
                d   = rnd64() & mask1(w);
                if (d == 0) d = 64'd1;
                hi  = rnd64() & mask1(w);
                if (cls != 0) hi = hi % d;
                lo  = rnd64() & mask1(w);
                dvd = ({64'd0, hi} << w) | {64'd0, lo};
                if (cls == 1) dvd = dvd | ({rnd64(), rnd64()} & ~mask2(w));
                run_op(s, (s != 3) ? 1'($urandom()) : 1'b1, dvd,
                       (cls == 1) ? (d | (rnd64() & ~mask1(w))) : d,
                       cls == 2, cls == 2 ? "R9 random busy start" : "R2 random");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule